// File: doc/BRIEF.md
# Dual-Mode Priority Interrupt Controller

This block arbitrates up to sixteen level-sensitive maskable interrupt sources and one edge-triggered non-maskable input for a small processor core. It keeps requests pending while they are blocked. It picks a single winner, raises a request line to the core, and grants the winner only when the core reports an instruction boundary. On a grant it emits a one-cycle acknowledge pulse with a vector number and updates the interrupt mask it holds.

A control bit selects one of two arbitration styles. In fixed mode, one global mask bit blocks every maskable source, and ranking follows source index. In level mode, each source carries a programmable 3-bit level. A 3-bit mask level then admits only sources ranked above it. The non-maskable input bypasses both masks in both modes. Configuration and mask state are loaded through a simple write port. The core writes the mask when it returns from a handler.

Top module: `prio_intc`

## Requirements
- R1: After reset the acknowledge output is low, the request line is low, the mode is fixed, the global mask bit is 0, the mask level is 0, and all source enables are 0.
- R2: Writes use these word addresses. Address 0 bit 0 is the mode (0 = fixed, 1 = level). Address 1 holds the mask, with bits 2:0 the mask level and bit 3 the global mask bit. Address 2 holds the enables, bit n for source n. Address 3+k holds levels: source 4k+j uses bits 4j+2..4j.
- R3: A source whose enable bit is 0 never raises the request line and is never granted, whatever its input.
- R4: In fixed mode, while the global mask bit is 1, no maskable source is requested or granted. Its request stays pending and is granted once the bit is cleared.
- R5: In fixed mode, the lowest-numbered eligible source wins.
- R6: In level mode, the eligible source with the highest level wins. On equal levels the lower index wins.
- R7: In level mode, a source is eligible only if its level is strictly greater than the mask level.
- R8: A grant happens only on a clock edge where the instruction-boundary input is 1 and the request line is 1. The acknowledge pulse follows in the next cycle for one cycle, with vector 0 for the non-maskable input and n+1 for source n.
- R9: A grant in fixed mode, including a non-maskable one, sets the global mask bit to 1.
- R10: A grant in level mode loads the mask level with the granted source's level. A non-maskable grant loads 7.
- R11: A rising edge on the non-maskable input is latched and outranks every maskable source in both modes, regardless of any mask. The latch clears on its grant, and an input held high does not request again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 4 | Configuration word address |
| wr_data | input | 16 | Configuration write data |
| nmi_in | input | 1 | Non-maskable interrupt, rising-edge sensitive |
| src_req | input | 16 | Maskable interrupt inputs, level sensitive |
| insn_done | input | 1 | Core is at an instruction boundary |
| irq_req | output | 1 | An eligible request is waiting |
| ack | output | 1 | One-cycle grant pulse |
| ack_vec | output | 5 | Vector number of the grant |
| mask_i | output | 1 | Global mask bit (fixed mode) |
| mask_lvl | output | 3 | Mask level (level mode) |

## Verification
A corrupted mask register shows at the ports in the very next cycle. Either irq_req drops for a source that should be eligible, or the mask outputs read a value different from the last write or grant. A wrong ranking or a stale non-maskable latch shows on the first grant that follows as a wrong ack_vec. A latch that fails to clear re-raises irq_req in the cycle after its grant. Each scenario therefore reads the request line straight after every mask change, and reads vector and mask one cycle after every boundary strobe.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int LVL_W = 3;
  localparam int SLOT_W = 4;

  typedef enum logic {
    MODE_FIXED = 1'b0,
    MODE_LEVEL = 1'b1
  } intc_mode_e;

  // ranking key used by the arbiter: levels only matter in level mode
  function automatic logic [LVL_W-1:0] rank_key(intc_mode_e mode, logic [LVL_W-1:0] lvl);
    return (mode == MODE_LEVEL) ? lvl : '0;
  endfunction

  // level-mode admission test
  function automatic logic lvl_admits(logic [LVL_W-1:0] lvl, logic [LVL_W-1:0] mask);
    return lvl > mask;
  endfunction

  // mask level loaded by a non-maskable grant (saturates the field)
  function automatic logic [LVL_W-1:0] nmi_mask_level();
    return '1;
  endfunction
endpackage

// File: rtl/intc_nmi_edge.sv
module intc_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic take_nmi,
  output logic nmi_pend,
  output logic nmi_edge
);
  logic nmi_q;

  assign nmi_edge = nmi_in & ~nmi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi_in;
      nmi_pend <= nmi_edge | (nmi_pend & ~take_nmi);
    end
  end

  // R11: a taken latch with no fresh edge is clear afterwards
  a_r11_nmi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (take_nmi && !nmi_edge) |=> !nmi_pend);
  // R11: a held-high input raises no new request
  a_r11_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_pend && $past(nmi_in) && nmi_in) |=> !nmi_pend);
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     take,
  input  logic                     take_nmi,
  input  logic [LVL_W-1:0]         take_lvl,
  output intc_mode_e               mode,
  output logic [NUM_SRC-1:0]       src_en,
  output logic [NUM_SRC*LVL_W-1:0] lvl_flat,
  output logic                     mask_i,
  output logic [LVL_W-1:0]         mask_lvl
);
  localparam int SLOTS     = DATA_W / SLOT_W;
  localparam int ADR_CTRL  = 0;
  localparam int ADR_MASK  = 1;
  localparam int ADR_EN    = 2;
  localparam int ADR_LVL0  = 3;

  logic wr_ctrl, wr_mask, wr_en_reg;
  assign wr_ctrl   = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
  assign wr_mask   = wr_en && (wr_addr == ADDR_W'(ADR_MASK));
  assign wr_en_reg = wr_en && (wr_addr == ADDR_W'(ADR_EN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= MODE_FIXED;
      src_en   <= '0;
      mask_i   <= 1'b0;
      mask_lvl <= '0;
    end else begin
      if (wr_ctrl)   mode   <= intc_mode_e'(wr_data[0]);
      if (wr_en_reg) src_en <= wr_data[NUM_SRC-1:0];
      if (take) begin
        // a grant overrides any mask write in the same cycle
        if (mode == MODE_FIXED) mask_i <= 1'b1;
        else mask_lvl <= take_nmi ? nmi_mask_level() : take_lvl;
      end else if (wr_mask) begin
        mask_lvl <= wr_data[LVL_W-1:0];
        mask_i   <= wr_data[LVL_W];
      end
    end
  end

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_lvl
    localparam int WORD = ADR_LVL0 + n / SLOTS;
    localparam int BASE = (n % SLOTS) * SLOT_W;
    logic [LVL_W-1:0] lvl_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(WORD)) lvl_q <= wr_data[BASE +: LVL_W];
    end
    assign lvl_flat[n*LVL_W +: LVL_W] = lvl_q;
  end

  wire unused_wdata = ^wr_data;

  // R9: fixed-mode grant leaves the global mask set
  a_r9_fixed_take_sets_i: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode == MODE_FIXED) |=> mask_i);
  // R10: level-mode grant never lowers the mask below the admitted level
  a_r10_level_take_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !take_nmi && mode == MODE_LEVEL) |=> (mask_lvl > $past(mask_lvl)));
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  parameter int VEC_W   = $clog2(NUM_SRC + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  intc_mode_e               mode,
  input  logic [NUM_SRC-1:0]       src_req,
  input  logic [NUM_SRC-1:0]       src_en,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_flat,
  input  logic                     mask_i,
  input  logic [LVL_W-1:0]         mask_lvl,
  input  logic                     nmi_pend,
  output logic                     win_valid,
  output logic                     win_nmi,
  output logic [LVL_W-1:0]         win_lvl,
  output logic [VEC_W-1:0]         win_vec,
  output logic [NUM_SRC-1:0]       grant
);
  logic [NUM_SRC-1:0] elig;

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_elig
    logic [LVL_W-1:0] lvl_n;
    logic             pass_n;
    assign lvl_n   = lvl_flat[n*LVL_W +: LVL_W];
    assign pass_n  = (mode == MODE_FIXED) ? !mask_i : lvl_admits(lvl_n, mask_lvl);
    assign elig[n] = src_req[n] & src_en[n] & pass_n;
  end

  logic             best_found;
  logic [IDX_W-1:0] best_idx;
  logic [LVL_W-1:0] best_key;
  logic [LVL_W-1:0] best_lvl;

  // scan from the top index down; ">=" lets a lower index take a tie
  always_comb begin
    best_found = 1'b0;
    best_idx   = '0;
    best_key   = '0;
    best_lvl   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i] && (!best_found ||
          rank_key(mode, lvl_flat[i*LVL_W +: LVL_W]) >= best_key)) begin
        best_found = 1'b1;
        best_idx   = IDX_W'(i);
        best_key   = rank_key(mode, lvl_flat[i*LVL_W +: LVL_W]);
        best_lvl   = lvl_flat[i*LVL_W +: LVL_W];
      end
    end
  end

  assign win_nmi   = nmi_pend;
  assign win_valid = nmi_pend | best_found;
  assign win_lvl   = best_lvl;
  assign win_vec   = nmi_pend ? '0 : VEC_W'(best_idx) + VEC_W'(1);
  assign grant     = (best_found && !nmi_pend) ? (NUM_SRC'(1) << best_idx) : '0;

  a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R3: a granted source is always enabled and requesting
  a_r3_grant_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~(src_en & src_req)) == '0));
  // R4: no maskable winner while the global mask is set
  a_r4_fixed_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !win_nmi && mode == MODE_FIXED) |-> !mask_i);
  // R7: a level-mode winner lies above the mask level
  a_r7_level_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !win_nmi && mode == MODE_LEVEL) |-> (win_lvl > mask_lvl));
  // R11: a pending latch always wins
  a_r11_nmi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend |-> (win_valid && grant == '0));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int DATA_W  = (NUM_SRC > 16) ? NUM_SRC : 16,
  parameter int ADDR_W  = 4,
  parameter int VEC_W   = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               nmi_in,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               insn_done,
  output logic               irq_req,
  output logic               ack,
  output logic [VEC_W-1:0]   ack_vec,
  output logic               mask_i,
  output logic [LVL_W-1:0]   mask_lvl
);
  intc_mode_e               mode;
  logic [NUM_SRC-1:0]       src_en;
  logic [NUM_SRC*LVL_W-1:0] lvl_flat;
  logic                     nmi_pend, nmi_edge;
  logic                     win_valid, win_nmi;
  logic [LVL_W-1:0]         win_lvl;
  logic [VEC_W-1:0]         win_vec;
  logic [NUM_SRC-1:0]       grant;
  logic                     take, take_nmi;

  assign take     = insn_done & win_valid;
  assign take_nmi = take & win_nmi;
  assign irq_req  = win_valid;

  intc_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .take(take), .take_nmi(take_nmi), .take_lvl(win_lvl),
    .mode(mode), .src_en(src_en), .lvl_flat(lvl_flat),
    .mask_i(mask_i), .mask_lvl(mask_lvl)
  );

  intc_nmi_edge u_nmi (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .take_nmi(take_nmi),
    .nmi_pend(nmi_pend), .nmi_edge(nmi_edge)
  );

  intc_arbiter #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .mode(mode), .src_req(src_req), .src_en(src_en),
    .lvl_flat(lvl_flat), .mask_i(mask_i), .mask_lvl(mask_lvl), .nmi_pend(nmi_pend),
    .win_valid(win_valid), .win_nmi(win_nmi), .win_lvl(win_lvl),
    .win_vec(win_vec), .grant(grant)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack     <= 1'b0;
      ack_vec <= '0;
    end else begin
      ack <= take;
      if (take) ack_vec <= win_vec;
    end
  end

  // R8: every acknowledge follows a boundary strobe with a waiting request
  a_r8_ack_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(insn_done && irq_req));
  // R8: the vector of a maskable grant matches the granted line
  a_r8_vec_matches_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !win_nmi) |-> grant[win_vec - VEC_W'(1)]);
endmodule

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        nmi_in = 1'b0;
  logic [15:0] src_req = '0;
  logic        insn_done = 1'b0;
  logic        irq_req, ack, mask_i;
  logic [4:0]  ack_vec;
  logic [2:0]  mask_lvl;

  int n_checks = 0;
  int n_fail = 0;
  logic [2:0] lvl_shadow [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_intc u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .nmi_in(nmi_in), .src_req(src_req), .insn_done(insn_done),
    .irq_req(irq_req), .ack(ack), .ack_vec(ack_vec), .mask_i(mask_i), .mask_lvl(mask_lvl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // address 1: bits 2:0 mask level, bit 3 global mask bit (R2)
  task automatic set_mask(input logic i_bit, input logic [2:0] lvl);
    wr(4'd1, {12'd0, i_bit, lvl});
  endtask

  task automatic set_level(input int src, input logic [2:0] lvl);
    logic [15:0] word;
    lvl_shadow[src] = lvl;
    word = '0;
    for (int j = 0; j < 4; j++) word[4*j +: 3] = lvl_shadow[(src/4)*4 + j];
    wr(4'(3 + src/4), word);
  endtask

  task automatic boundary(input string tag, input logic exp_ack, input int exp_vec);
    insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0;
    chk({tag, " ack"}, int'(ack), int'(exp_ack));
    if (exp_ack) begin
      chk({tag, " vec"}, int'(ack_vec), exp_vec);
      @(negedge clk);
      chk({tag, " ack one cycle"}, int'(ack), 0);
    end
  endtask

  task automatic t_reset();
    chk("R1 ack", int'(ack), 0);
    chk("R1 irq_req", int'(irq_req), 0);
    chk("R1 mask_i", int'(mask_i), 0);
    chk("R1 mask_lvl", int'(mask_lvl), 0);
  endtask

  task automatic t_disabled();
    src_req = 16'hFFFF;
    @(negedge clk);
    chk("R3 disabled no irq", int'(irq_req), 0);
    boundary("R3 disabled no grant", 1'b0, 0);
    src_req = '0;
  endtask

  task automatic t_fixed_order();
    wr(4'd2, 16'hFFFF);
    src_req = 16'h0220;                    // sources 5 and 9
    @(negedge clk);
    chk("R8 no grant without boundary", int'(ack), 0);
    boundary("R5 lowest index wins", 1'b1, 6);
    chk("R9 mask_i set", int'(mask_i), 1);
    set_mask(1'b0, 3'd0);
    wr(4'd2, 16'h0200);                    // only source 9 enabled
    boundary("R3 enable filters", 1'b1, 10);
    wr(4'd2, 16'hFFFF);
  endtask

  task automatic t_fixed_mask();
    // mask_i is 1 from the previous grant
    chk("R4 masked no irq", int'(irq_req), 0);
    boundary("R4 masked no grant", 1'b0, 0);
    set_mask(1'b0, 3'd0);
    chk("R4 pending after unmask", int'(irq_req), 1);
    boundary("R4 grant after unmask", 1'b1, 6);
    src_req = '0;
  endtask

  task automatic t_level_mode();
    wr(4'd0, 16'd1);
    set_mask(1'b0, 3'd0);
    set_level(3, 3'd5); set_level(7, 3'd5); set_level(10, 3'd6);
    wr(4'd2, 16'h0488);
    src_req = 16'h0488;
    boundary("R6 highest level wins", 1'b1, 11);
    chk("R10 mask loaded", int'(mask_lvl), 6);
    chk("R7 below mask blocked", int'(irq_req), 0);
    set_mask(1'b0, 3'd0);
    src_req = 16'h0088;
    boundary("R6 tie lower index", 1'b1, 4);
    chk("R10 mask loaded tie", int'(mask_lvl), 5);
    chk("R7 equal level blocked", int'(irq_req), 0);
    set_mask(1'b0, 3'd4);
    chk("R7 above mask eligible", int'(irq_req), 1);
    boundary("R7 grant above mask", 1'b1, 4);
  endtask

  task automatic t_nmi();
    set_mask(1'b0, 3'd7);
    chk("R7 full mask no irq", int'(irq_req), 0);
    nmi_in = 1'b1;
    @(negedge clk);
    chk("R11 edge latched", int'(irq_req), 1);
    boundary("R11 nmi vector", 1'b1, 0);
    chk("R10 nmi mask 7", int'(mask_lvl), 7);
    chk("R11 held high no retrigger", int'(irq_req), 0);
    // fixed mode, global mask set, sources requesting
    wr(4'd0, 16'd0);
    set_mask(1'b1, 3'd0);
    nmi_in = 1'b0;
    @(negedge clk);
    nmi_in = 1'b1;
    set_mask(1'b0, 3'd0);                  // unmask: sources 3, 7 eligible
    chk("R11 nmi pending with sources", int'(irq_req), 1);
    boundary("R11 nmi outranks sources", 1'b1, 0);
    chk("R9 nmi sets mask_i", int'(mask_i), 1);
    nmi_in = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < 16; k++) lvl_shadow[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_fixed_order();
    t_fixed_mask();
    t_level_mode();
    t_nmi();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule